// File: doc/BRIEF.md
# Light-Load Mode Selection Controller

This block decides, for one buck channel, whether the converter runs in fixed-frequency PWM operation or in hysteretic operation at light load. Once per switching cycle a strobe captures the level of the inductor-current comparator. A high level means the inductor current stayed continuous. A low level means the current went discontinuous. Two independent run-length detectors watch these samples. One needs a run of lows to leave PWM operation, and the other needs a run of highs to return. A single contrary sample wipes out a partial run. This keeps the mode from chattering when the load sits near the critical current.

The mode is stored in a set/reset flip-flop. While the hysteretic flag is high, the synchronous switch is also placed in diode emulation, so it may not carry reverse current. When the reference voltage is being moved, a force request pins the channel in PWM operation until the request drops. Both run counters restart from zero on every mode change and on the release of the force request.

Top module: `lightload_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `hyst_mode` is 0 and both run counts are zero. From there, exactly `RUN_LEN` (default 8) qualifying samples are needed before the mode can change.
- R2: In PWM mode (`hyst_mode`=0), `RUN_LEN` consecutive strobes that each sample `ccm_level`=0 set `hyst_mode` to 1. The change appears at the clock edge that captures the last of those strobes.
- R3: In PWM mode, a strobe that samples `ccm_level`=1 clears the partial low run. A further `RUN_LEN` consecutive low samples are then needed.
- R4: In hysteretic mode, `RUN_LEN` consecutive strobes that each sample `ccm_level`=1 clear `hyst_mode` to 0. The change appears at the edge that captures the last of those strobes.
- R5: In hysteretic mode, a strobe that samples `ccm_level`=0 clears the partial high run and leaves the mode unchanged.
- R6: While `force_pwm` is 1, `hyst_mode` is 0 from the next clock edge onward. Strobes are ignored during this time, including one that would have completed a run.
- R7: When `force_pwm` falls, counting starts from zero. A run built up before the force request does not carry over.
- R8: In a cycle with `sample_stb`=0 and `force_pwm`=0, `hyst_mode` and both run counts keep their values, whatever the `ccm_level` input is.
- R9: `pwm_mode` is always the complement of `hyst_mode`.
- R10: On every mode change, both run counts restart at zero. The count for the mode already in effect is held at zero, so samples that agree with the current mode have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle strobe, once per switching cycle |
| ccm_level | input | 1 | Comparator level: 1 means continuous current, 0 means discontinuous |
| force_pwm | input | 1 | Request to hold PWM operation during a reference transition |
| hyst_mode | output | 1 | 1 selects hysteretic operation with diode emulation |
| pwm_mode | output | 1 | 1 selects fixed-frequency PWM operation |

## Verification
Two events can fall in the same cycle: the strobe that completes a run, and a force request. The force request must win, leaving the channel in PWM mode and discarding the run. The bench builds a low run one sample short of the limit and then raises the force request together with the completing strobe. It then releases the request and checks that a run one sample short still does not switch the mode, while a full run does. Random phases also raise the force request and strobes together often, and every such cycle is compared with the bench's own mode model.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  // Next run count: a hit extends the run, a miss clears it, and a completed run wraps to zero.
  function automatic int unsigned run_next(input int unsigned cnt, input logic hit,
                                           input int unsigned run_len);
    if (!hit) return 0;
    if (cnt + 1 >= run_len) return 0;
    return cnt + 1;
  endfunction

  // A run completes when a hit arrives with the count at its last position.
  function automatic logic run_done(input int unsigned cnt, input logic hit,
                                    input int unsigned run_len);
    return hit && (cnt + 1 >= run_len);
  endfunction
endpackage

// File: rtl/lmc_run_detector.sv
module lmc_run_detector
  import lmc_pkg::*;
#(
  parameter int unsigned RUN_LEN = 8,
  parameter logic        MATCH   = 1'b0,
  localparam int unsigned CW     = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          stb,
  input  logic          level,
  output logic          fire,
  output logic [CW-1:0] count
);
  logic hit;
  logic [CW-1:0] cnt_q;

  assign hit   = arm && stb && (level == MATCH);
  assign fire  = run_done(int'(cnt_q), hit, RUN_LEN);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!arm)   cnt_q <= '0;
    else if (stb)    cnt_q <= CW'(run_next(int'(cnt_q), hit, RUN_LEN));
  end

  // R10: a disarmed detector reads zero on the next cycle
  a_r10_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (count == '0));
  // R3 / R5: a contrary strobe clears the run
  a_r3_contrary_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && stb && level != MATCH) |=> (count == '0));
  // R8: no strobe, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !stb) |=> $stable(count));
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) < RUN_LEN);
endmodule

// File: rtl/lmc_mode_latch.sv
module lmc_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic force_clr,
  input  logic set_req,
  input  logic clr_req,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         q <= 1'b0;
    else if (force_clr) q <= 1'b0;
    else if (set_req)   q <= 1'b1;
    else if (clr_req)   q <= 1'b0;
  end

  // R10: the two run detectors are never both completing
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_req && clr_req));
  // R6: force wins
  a_r6_force_wins: assert property (@(posedge clk) disable iff (!rst_n)
    force_clr |=> !q);
endmodule

// File: rtl/lightload_mode_ctrl.sv
module lightload_mode_ctrl #(
  parameter int unsigned RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_stb,
  input  logic ccm_level,
  input  logic force_pwm,
  output logic hyst_mode,
  output logic pwm_mode
);
  localparam int unsigned CW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;

  logic          mode_q;
  logic          enter_arm, leave_arm;
  logic          enter_fire, leave_fire;
  logic [CW-1:0] enter_cnt, leave_cnt;

  // Only the detector for the opposite mode counts, and neither counts while forced.
  assign enter_arm = !force_pwm && !mode_q;
  assign leave_arm = !force_pwm &&  mode_q;

  lmc_run_detector #(.RUN_LEN(RUN_LEN), .MATCH(1'b0)) u_enter (
    .clk(clk), .rst_n(rst_n), .arm(enter_arm), .stb(sample_stb),
    .level(ccm_level), .fire(enter_fire), .count(enter_cnt));

  lmc_run_detector #(.RUN_LEN(RUN_LEN), .MATCH(1'b1)) u_leave (
    .clk(clk), .rst_n(rst_n), .arm(leave_arm), .stb(sample_stb),
    .level(ccm_level), .fire(leave_fire), .count(leave_cnt));

  lmc_mode_latch u_latch (
    .clk(clk), .rst_n(rst_n), .force_clr(force_pwm),
    .set_req(enter_fire), .clr_req(leave_fire), .q(mode_q));

  assign hyst_mode = mode_q;
  assign pwm_mode  = !mode_q;

  // R2: entry into hysteretic mode only follows a low strobe
  a_r2_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hyst_mode) |-> $past(sample_stb && !ccm_level && !force_pwm));
  // R4 / R6: exit follows a high strobe or a force request
  a_r4_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hyst_mode) |-> $past(force_pwm || (sample_stb && ccm_level)));
  // R8: without strobe or force the mode holds
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_stb && !force_pwm) |=> $stable(hyst_mode));
  // R10: a mode change leaves both counts at zero
  a_r10_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hyst_mode != $past(hyst_mode)) |-> (enter_cnt == '0 && leave_cnt == '0));
endmodule

// File: tb/lightload_mode_ctrl_bench.sv
module lightload_mode_ctrl_bench;
  localparam int RUN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_stb = 1'b0, ccm_level = 1'b0, force_pwm = 1'b0;
  logic hyst_mode, pwm_mode;

  int total = 0, bad = 0;
  bit m_hyst = 0;
  int m_lo = 0, m_hi = 0;

  always #5 clk = ~clk;

  lightload_mode_ctrl #(.RUN_LEN(RUN)) u_lightload_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .ccm_level(ccm_level),
    .force_pwm(force_pwm), .hyst_mode(hyst_mode), .pwm_mode(pwm_mode));

  function automatic void model(input bit s, input bit l, input bit f);
    if (f) begin m_hyst = 0; m_lo = 0; m_hi = 0; end
    else if (s) begin
      if (!m_hyst) begin
        m_hi = 0;
        m_lo = l ? 0 : m_lo + 1;
        if (m_lo == RUN) begin m_hyst = 1; m_lo = 0; end
      end else begin
        m_lo = 0;
        m_hi = l ? m_hi + 1 : 0;
        if (m_hi == RUN) begin m_hyst = 0; m_hi = 0; end
      end
    end
  endfunction

  task automatic chk(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit s, input bit l, input bit f, input string tag);
    @(negedge clk);
    sample_stb = s; ccm_level = l; force_pwm = f;
    @(posedge clk);
    #1;
    model(s, l, f);
    chk(hyst_mode, m_hyst, tag);
    chk(pwm_mode, !m_hyst, "R9");
  endtask

  task automatic run(input int n, input bit l, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, l, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk(hyst_mode, 1'b0, "R1");
    chk(pwm_mode, 1'b1, "R9");
    @(negedge clk); rst_n = 1'b1;
    // R1 / R2: exactly RUN lows after reset
    run(RUN - 1, 1'b0, "R1");
    run(1, 1'b0, "R2");
    // R10: lows in hysteretic mode have no effect; then R4 needs RUN highs
    run(5, 1'b0, "R10");
    run(RUN - 1, 1'b1, "R10");
    run(1, 1'b1, "R4");
    // R3: contrary high breaks the low run
    run(RUN - 1, 1'b0, "R3");
    run(1, 1'b1, "R3");
    run(RUN - 1, 1'b0, "R3");
    run(1, 1'b0, "R2");
    // R5: contrary low breaks the high run
    run(RUN - 1, 1'b1, "R5");
    run(1, 1'b0, "R5");
    run(RUN - 1, 1'b1, "R5");
    // R8: no strobe, level toggling
    for (int i = 0; i < 6; i++) step(1'b0, i[0], 1'b0, "R8");
    run(1, 1'b1, "R4");
    // R6: force arrives with the completing strobe
    run(RUN - 1, 1'b0, "R6");
    step(1'b1, 1'b0, 1'b1, "R6");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b1, "R6");
    // R7: release starts from zero
    run(RUN - 1, 1'b0, "R7");
    run(1, 1'b0, "R7");
    // R6: force drops hysteretic mode at once
    step(1'b0, 1'b1, 1'b1, "R6");
    step(1'b0, 1'b1, 1'b0, "R7");
    // random phase with runs of level
    begin
      bit lv = 0;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(0, 9) == 0) lv = ~lv;
        step($urandom_range(0, 3) != 0, lv, $urandom_range(0, 39) == 0, "R10");
      end
    end
    // reset mid-run clears counts
    run(RUN - 2, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b0; sample_stb = 0;
    @(posedge clk); #1; m_hyst = 0; m_lo = 0; m_hi = 0;
    chk(hyst_mode, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    run(RUN - 1, 1'b0, "R1");
    run(1, 1'b0, "R2");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule